// File: doc/BRIEF.md
# Gated Multi-Channel Rate Counter

This block measures event rates on five trigger lines at once: four patch inputs and one combined-trigger input. Each line is synchronised and edge-detected, and every rising edge adds one to that line's counter. All five counters share one measurement window. A tick divider paces the window timer, and an 8-bit prescale value `y` sets the window to `y+1` half-second units. At the end of each full window the five counts and their overflow bits are copied to the result outputs, a one-cycle `res_valid` strobe fires, and every counter starts again from zero.

A pulse on `settings_chg` aborts the window in progress. The timer and all counters are cleared, nothing is published for the cut-short window, and a fresh full window begins. The result outputs are a plain strobe-and-hold interface with no back-pressure. A consumer must capture them in the cycle `res_valid` is high, or at any time before the next strobe, because the values hold until then.

Top module: `rate_window_counter`

## Requirements
- R1: While `rst_n` is low and after its release, `res_valid`, `res_counts` and `res_ovf` are all zero until the first window completes.
- R2: A rising edge on any trigger input adds exactly one to that channel's count. An input held high for many cycles counts once. Channel index 0..3 is `trig_patch[0..3]` and index 4 is `trig_comb`.
- R3: A counter stops at 2^CNT_W-1. The first edge that would push it past that value sets the channel's overflow bit. Count and bit stay that way until the window ends.
- R4: A window lasts `(prescale+1)*TICKS_PER_HALF` ticks, and one tick is `CLK_PER_TICK` clock cycles. Consecutive `res_valid` strobes are therefore exactly `(prescale+1)*TICKS_PER_HALF*CLK_PER_TICK` cycles apart, and each strobe lasts one cycle.
- R5: When `settings_chg` is high at a clock edge, the timer and all counters clear and no strobe follows for the interrupted window. The next strobe comes one full window after that edge, and it carries only the edges seen after it.
- R6: Channel i occupies `res_counts[32*i+31:32*i]`, with byte 0 in bits 7:0 (little-endian). The count is zero-extended, so bits 31:30 of every channel are always 0.
- R7: `res_ovf` bit i is channel i's overflow bit (bit 0 A, 1 B, 2 C, 3 D, 4 combined), and bits 7:5 are 0.
- R8: Between strobes, `res_counts` and `res_ovf` keep the last published values, including across a `settings_chg`.
- R9: Each window starts every counter from zero, so no count carries from one window into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_patch | input | N_PATCH | Asynchronous patch trigger lines |
| trig_comb | input | 1 | Asynchronous combined trigger line |
| prescale | input | 8 | Window length selector y; window = y+1 half-second units |
| settings_chg | input | 1 | Abort and restart the window, discarding partial counts |
| res_valid | output | 1 | One-cycle strobe: new results published |
| res_counts | output | (N_PATCH+1)*32 | Published counts, 32 bits per channel |
| res_ovf | output | 8 | Published overflow bits |

## Verification
The main sweep runs many windows in a row. In each one, every channel receives a different pulse count between 0 and 20, and the counter is set to 4 bits wide. This separates a correct count, a count that leaks from one channel into another, a count that carries over from the previous window, and saturation with its overflow bit at and beyond 15. A line held high for most of a window separates edge counting from level counting. Changing the prescale between windows checks the window length against the arithmetic formula. A `settings_chg` in the middle of a window, with pulses on both sides of it, shows that the partial window is dropped, that the restart is timed from the abort, and that the earlier results stay in place.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  localparam int OUT_W = 32;
  localparam int OVF_W = 8;
  localparam int PS_W  = 8;
endpackage

// File: rtl/rwc_sync_edge.sv
module rwc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], din};
  end

  assign rise = sh_q[1] & ~sh_q[2];
endmodule

// File: rtl/rwc_window_timer.sv
module rwc_window_timer #(
  parameter int CLK_PER_TICK   = 50,
  parameter int TICKS_PER_HALF = 500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic [rwc_pkg::PS_W-1:0] prescale,
  output logic                    done
);
  localparam int DIV_W = $clog2(CLK_PER_TICK) + 1;
  localparam int WIN_W = $clog2(256 * TICKS_PER_HALF + 1) + 1;

  logic [DIV_W-1:0] div_q;
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] last_tick;
  logic             tick;

  always_comb begin
    last_tick = ({{(WIN_W-9){1'b0}}, {1'b0, prescale} + 9'd1} * WIN_W'(TICKS_PER_HALF))
                - WIN_W'(1);
  end

  assign tick = (div_q == DIV_W'(CLK_PER_TICK - 1));
  assign done = tick && (win_q == last_tick);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      div_q <= '0;
      win_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
      if (tick) win_q <= done ? '0 : win_q + WIN_W'(1);
    end
  end

  // R4: the timer never runs past the selected window
  a_r4_win_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= last_tick || $changed(prescale) || $past(restart));
endmodule

// File: rtl/rwc_sat_counter.sv
module rwc_sat_counter #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         start,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (start) begin
      cnt <= inc ? W'(1) : '0;
      ovf <= 1'b0;
    end else if (inc) begin
      if (cnt == MAX) ovf <= 1'b1;
      else            cnt <= cnt + W'(1);
    end
  end

  a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> cnt == MAX);
  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear && !start) |=> ovf);
  a_r2_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !start) |=> cnt >= $past(cnt));
endmodule

// File: rtl/rate_window_counter.sv
module rate_window_counter #(
  parameter int N_PATCH        = 4,
  parameter int CNT_W          = 30,
  parameter int CLK_PER_TICK   = 50,
  parameter int TICKS_PER_HALF = 500000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [N_PATCH-1:0]                    trig_patch,
  input  logic                                  trig_comb,
  input  logic [rwc_pkg::PS_W-1:0]              prescale,
  input  logic                                  settings_chg,
  output logic                                  res_valid,
  output logic [(N_PATCH+1)*rwc_pkg::OUT_W-1:0] res_counts,
  output logic [rwc_pkg::OVF_W-1:0]             res_ovf
);
  import rwc_pkg::*;
  localparam int NCH = N_PATCH + 1;

  logic [NCH-1:0]       trig_all;
  logic [NCH-1:0]       rise;
  logic [NCH-1:0]       ovf_vec;
  logic [NCH*OUT_W-1:0] cnt_packed;
  logic                 win_done;

  assign trig_all = {trig_comb, trig_patch};

  rwc_window_timer #(
    .CLK_PER_TICK  (CLK_PER_TICK),
    .TICKS_PER_HALF(TICKS_PER_HALF)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (settings_chg),
    .prescale(prescale),
    .done    (win_done)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CNT_W-1:0] cnt;
    rwc_sync_edge u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (trig_all[i]),
      .rise (rise[i])
    );
    rwc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(settings_chg),
      .start(win_done),
      .inc  (rise[i]),
      .cnt  (cnt),
      .ovf  (ovf_vec[i])
    );
    assign cnt_packed[i*OUT_W +: OUT_W] = {{(OUT_W-CNT_W){1'b0}}, cnt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_counts <= '0;
      res_ovf    <= '0;
    end else if (settings_chg) begin
      res_valid <= 1'b0;
    end else if (win_done) begin
      res_valid  <= 1'b1;
      res_counts <= cnt_packed;
      res_ovf    <= {{(OVF_W-NCH){1'b0}}, ovf_vec};
    end else begin
      res_valid <= 1'b0;
    end
  end

  a_r5_chg_no_publish: assert property (@(posedge clk) disable iff (!rst_n)
    settings_chg |=> !res_valid);
  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_counts) && $stable(res_ovf)));
  a_r7_ovf_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_ovf[OVF_W-1:NCH] == '0);
endmodule

// File: tb/tb_rate_window_counter.sv
`timescale 1ns/1ps
module tb_rate_window_counter;
  localparam int NP  = 4;
  localparam int NCH = NP + 1;
  localparam int CW  = 4;
  localparam int CPT = 2;
  localparam int TPH = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NP-1:0]     trig_patch = '0;
  logic              trig_comb = 1'b0;
  logic [7:0]        prescale = 8'd15;
  logic              settings_chg = 1'b0;
  logic              res_valid;
  logic [NCH*32-1:0] res_counts;
  logic [7:0]        res_ovf;

  int n_cmp = 0;
  int n_bad = 0;
  int kset[NCH];
  int ncyc;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rate_window_counter #(
    .N_PATCH(NP), .CNT_W(CW), .CLK_PER_TICK(CPT), .TICKS_PER_HALF(TPH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .trig_patch(trig_patch), .trig_comb(trig_comb),
    .prescale(prescale), .settings_chg(settings_chg), .res_valid(res_valid),
    .res_counts(res_counts), .res_ovf(res_ovf)
  );

  function automatic int win_len(input int y);
    return (y + 1) * TPH * CPT;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [NCH-1:0] v);
    trig_patch = v[NP-1:0];
    trig_comb  = v[NP];
  endtask

  // pulses per kset: 2 cycles high, 2 low; counts negedges in ncyc
  task automatic pulses();
    int mx = 0;
    for (int i = 0; i < NCH; i++) if (kset[i] > mx) mx = kset[i];
    for (int j = 0; j < mx; j++) begin
      logic [NCH-1:0] v;
      for (int i = 0; i < NCH; i++) v[i] = (j < kset[i]);
      drive(v);
      repeat (2) begin @(negedge clk); ncyc++; end
      drive('0);
      repeat (2) begin @(negedge clk); ncyc++; end
    end
  endtask

  task automatic wait_valid();
    while (!res_valid && ncyc < 5000) begin @(negedge clk); ncyc++; end
  endtask

  task automatic check_results(input string tag);
    logic [7:0] exp_ovf = '0;
    for (int i = 0; i < NCH; i++) begin
      int e = (kset[i] > MAXC) ? MAXC : kset[i];
      exp_ovf[i] = (kset[i] > MAXC);
      check({tag, " R2/R3/R9 count"}, res_counts[i*32 +: 32], e);
      check({tag, " R6 top bits"}, res_counts[i*32+30 +: 2], 0);
    end
    check({tag, " R7 ovf byte"}, res_ovf, exp_ovf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid in reset", res_valid, 0);
    check("R1 counts in reset", res_counts == '0, 1);
    check("R1 ovf in reset", res_ovf, 0);
    rst_n = 1'b1;
    ncyc = 0;
    @(negedge clk); ncyc++;
    check("R1 valid after reset", res_valid, 0);
    wait_valid();
    check("R4 first window length", ncyc, win_len(15));
    for (int i = 0; i < NCH; i++) kset[i] = 0;
    check_results("R1 empty window");
    @(negedge clk);
    check("R4 strobe one cycle", res_valid, 0);
    wait_valid();

    // sweep of pulse counts per channel, consecutive windows
    for (int k = 0; k < 21; k++) begin
      for (int i = 0; i < NCH; i++) kset[i] = (k + 3 * i) % 21;
      ncyc = 0;
      pulses();
      wait_valid();
      check("R4 period", ncyc, win_len(15));
      check_results("sweep");
    end

    // held level counts once (R2)
    for (int i = 0; i < NCH; i++) kset[i] = 0;
    kset[2] = 1;
    drive(5'b00100);
    ncyc = 0;
    repeat (60) begin @(negedge clk); ncyc++; end
    drive('0);
    wait_valid();
    check_results("R2 held high");

    // prescale changes (R4)
    for (int s = 0; s < 4; s++) begin
      int y = (s == 3) ? 7 : s;
      @(negedge clk);
      prescale = 8'(y);
      wait_valid();
      ncyc = 0;
      @(negedge clk); ncyc++;
      wait_valid();
      check("R4 window for prescale", ncyc, win_len(y));
    end
    prescale = 8'd15;
    @(negedge clk);
    wait_valid();

    // settings change mid-window (R5, R8)
    for (int i = 0; i < NCH; i++) kset[i] = 6 + i;
    ncyc = 0;
    pulses();
    begin
      logic [NCH*32-1:0] held;
      held = res_counts;
      settings_chg = 1'b1;
      @(negedge clk);
      settings_chg = 1'b0;
      ncyc = 1;
      check("R8 results held after abort", res_counts == held, 1);
      check("R5 no strobe on abort", res_valid, 0);
    end
    for (int i = 0; i < NCH; i++) kset[i] = 3 - (i % 2);
    pulses();
    wait_valid();
    check("R5 restart timing", ncyc, win_len(15) + 1);
    check_results("R5 post-abort");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule